// File: doc/BRIEF.md
# Shared Slave Port Arbiter

This block decides which of several bus masters owns one shared slave port of a multi-layer interconnect. Each master raises a request line. The arbiter answers with a registered one-hot grant, the binary index of the owner and a grant-valid flag. While a master owns the port, the arbiter watches two inputs from that master: beat-valid and last-beat. It re-runs arbitration only at defined points. These are the end of a burst, the expiry of a programmable slot length, the owner falling silent, or any cycle in which no burst is in progress.

Three registers set the behaviour. They are written through a small synchronous write port. A configuration word selects round-robin or fixed-priority arbitration. The same word chooses what happens when nobody requests: release the port, park on the last owner, or park on a fixed master. It also sets the slot length. Two priority words hold a 4-bit priority for each master. Arbitration decisions read the registers only at arbitration points. The slot length is captured when a burst starts, so a write never disturbs a burst that is already running.

The controller has three named states. IDLE means no grant. PARK means the grant is held by a default master with no burst running. BURST means a requester owns the port. The transitions are as follows. IDLE/PARK→BURST on any request (ARBITRATE_WIN). BURST→BURST when a new winner is chosen at a burst end, at slot expiry or when the owner is silent (REARBITRATE). BURST/PARK/IDLE→PARK when nothing is requested and a parking policy applies (PARK_DEFAULT). Any state→IDLE when nothing is requested and no parking applies (RELEASE).

Top module: `slave_arbiter`

## Requirements
- R1: While reset is asserted and after its release with no requests, grant is all zeros, grant_valid is 0 and grant_id is 0.
- R2: The grant is registered and at most one bit is set. grant_id is the index of that bit. A request that arrives while no burst runs is granted on the next clock edge.
- R3: Arbitration-type bit 24 of the configuration word (register address 1 selects prio word A, address 0 the configuration word) set to 1 selects fixed priority. Master m below 8 takes its priority from bits 4m+3:4m of prio word A (address 1). Master m from 8 takes it from bits 4(m-8)+3:4(m-8) of prio word B (address 2). The highest value wins, and a tie goes to the lowest index.
- R4: Bit 24 set to 0 selects round-robin. The search starts at the master after the last granted one and wraps around. After reset it starts at master 0.
- R5: During a burst, the grant stays on its owner while the owner keeps requesting and no pre-emption applies. A beat with beat_valid=1 and beat_last=1 re-runs arbitration at that clock edge.
- R6: Configuration bits 7:0 hold a slot length L. When L is non-zero, a burst is pre-empted and arbitration re-runs after the grant has been held for L cycles. L=0 disables the cut-off.
- R7: The default policy sits in configuration bits 17:16. Policy 0 (or 3) with no requests deasserts all grants at the next arbitration point.
- R8: Policy 1 with no requests keeps the grant parked on the last granted master. If no master has been granted since reset, no grant is given.
- R9: Policy 2 with no requests parks the grant on the master whose ID is in configuration bits 21:18. If that ID is not below the master count, no grant is given.
- R10: Writes with cfg_we=1 go to address 0 (configuration), 1 (prio word A) or 2 (prio word B). Address 3 is ignored. A slot length written during a running burst does not change that burst. A new mode or priority takes effect at the next arbitration point.
- R11: During a burst, a cycle in which the owner's request is low and beat_valid is 0 counts as an idle slave. Arbitration re-runs at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | N_MST | One request per master |
| beat_valid | input | 1 | Owner presents a beat this cycle |
| beat_last | input | 1 | The current beat ends the burst |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 2 | Register select (0 config, 1 prio A, 2 prio B) |
| cfg_wdata | input | 32 | Register write data |
| grant | output | N_MST | One-hot grant |
| grant_id | output | 4 | Index of the granted master |
| grant_valid | output | 1 | A grant is active |

## Verification
A wrong owner or wrong state shows at grant and grant_id on the clock edge after the decision that went wrong. The reference model predicts every edge, so a bad round-robin pointer shows up at the very next contested arbitration. The same holds for a stale slot counter or a missed parking decision: each appears within one burst or one slot length. A slot length latched at the wrong time shows up as a burst cut short or run long, by a number of cycles that the per-cycle comparison counts exactly.

// File: rtl/arb_cfg_pkg.sv
package arb_cfg_pkg;
    localparam int ARB_TYPE_BIT = 24;
    localparam int POL_LSB      = 16;
    localparam int FIX_LSB      = 18;
    localparam int FIX_W        = 4;
    localparam int SLOT_W       = 8;
    localparam int PRIO_W       = 4;
    localparam int WORD_W       = 32;
    localparam int PRIO_PER_WORD = WORD_W / PRIO_W;

    localparam logic [1:0] REG_CFG     = 2'd0;
    localparam logic [1:0] REG_PRIO_LO = 2'd1;
    localparam logic [1:0] REG_PRIO_HI = 2'd2;

    typedef enum logic [1:0] {
        ARB_IDLE  = 2'd0,
        ARB_PARK  = 2'd1,
        ARB_BURST = 2'd2
    } arb_state_e;

    typedef enum logic [1:0] {
        POL_NONE  = 2'd0,
        POL_LAST  = 2'd1,
        POL_FIXED = 2'd2,
        POL_RSVD  = 2'd3
    } park_pol_e;
endpackage

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
    parameter int N_MST = 10,
    parameter int ID_W  = 4
) (
    input  logic [N_MST-1:0] req,
    input  logic [ID_W-1:0]  last_id,
    output logic             found,
    output logic [ID_W-1:0]  win_id
);
    logic             found_hi;
    logic [ID_W-1:0]  win_hi;
    logic             found_lo;
    logic [ID_W-1:0]  win_lo;

    // first requester strictly above the last owner
    always_comb begin
        found_hi = 1'b0;
        win_hi   = '0;
        for (int m = 0; m < N_MST; m++) begin
            if (!found_hi && req[m] && (ID_W'(m) > last_id)) begin
                found_hi = 1'b1;
                win_hi   = ID_W'(m);
            end
        end
    end

    // wrap: first requester at or below the last owner
    always_comb begin
        found_lo = 1'b0;
        win_lo   = '0;
        for (int m = 0; m < N_MST; m++) begin
            if (!found_lo && req[m] && (ID_W'(m) <= last_id)) begin
                found_lo = 1'b1;
                win_lo   = ID_W'(m);
            end
        end
    end

    assign found  = found_hi | found_lo;
    assign win_id = found_hi ? win_hi : win_lo;
endmodule

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
    parameter int N_MST  = 10,
    parameter int ID_W   = 4,
    parameter int PRIO_W = 4
) (
    input  logic [N_MST-1:0]             req,
    input  logic [N_MST-1:0][PRIO_W-1:0] prio,
    output logic                         found,
    output logic [ID_W-1:0]              win_id
);
    logic [PRIO_W-1:0] best;

    // strict compare keeps the lowest index on a tie
    always_comb begin
        found  = 1'b0;
        win_id = '0;
        best   = '0;
        for (int m = 0; m < N_MST; m++) begin
            if (req[m] && (!found || (prio[m] > best))) begin
                found  = 1'b1;
                win_id = ID_W'(m);
                best   = prio[m];
            end
        end
    end
endmodule

// File: rtl/arb_slot_timer.sv
module arb_slot_timer #(
    parameter int SLOT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              run,
    input  logic [SLOT_W-1:0] lim_in,
    output logic              expire,
    output logic [SLOT_W-1:0] cnt,
    output logic [SLOT_W-1:0] lim
);
    logic [SLOT_W-1:0] cnt_q;
    logic [SLOT_W-1:0] lim_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lim_q <= '0;
        end else if (start) begin
            cnt_q <= '0;
            lim_q <= lim_in;
        end else if (run && (lim_q != '0)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expire = run && (lim_q != '0) && (cnt_q == lim_q - 1'b1);
    assign cnt    = cnt_q;
    assign lim    = lim_q;
endmodule

// File: rtl/slave_arbiter.sv
module slave_arbiter
    import arb_cfg_pkg::*;
#(
    parameter int N_MST = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_MST-1:0] req,
    input  logic             beat_valid,
    input  logic             beat_last,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_addr,
    input  logic [31:0]      cfg_wdata,
    output logic [N_MST-1:0] grant,
    output logic [3:0]       grant_id,
    output logic             grant_valid
);
    localparam int ID_W = FIX_W;

    // configuration fields
    logic                         mode_prio_q;
    park_pol_e                    pol_q;
    logic [FIX_W-1:0]             fix_id_q;
    logic [SLOT_W-1:0]            slot_q;
    logic [N_MST-1:0][PRIO_W-1:0] prio_q;
    logic                         unused_wdata;

    // arbitration state
    arb_state_e        state_q, state_d;
    logic [ID_W-1:0]   own_q, own_d;
    logic [ID_W-1:0]   last_q;
    logic              last_vld_q;

    logic              rr_found, pr_found, any_found;
    logic [ID_W-1:0]   rr_win, pr_win, win_id;
    logic              own_req;
    logic              arb_pt;
    logic              slot_start;
    logic              expire;
    logic [SLOT_W-1:0] slot_cnt;
    logic [SLOT_W-1:0] slot_lim;

    assign unused_wdata = ^cfg_wdata;

    // register writes: configuration word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_prio_q <= 1'b0;
            pol_q       <= POL_NONE;
            fix_id_q    <= '0;
            slot_q      <= '0;
        end else if (cfg_we && (cfg_addr == REG_CFG)) begin
            mode_prio_q <= cfg_wdata[ARB_TYPE_BIT];
            pol_q       <= park_pol_e'(cfg_wdata[POL_LSB +: 2]);
            fix_id_q    <= cfg_wdata[FIX_LSB +: FIX_W];
            slot_q      <= cfg_wdata[SLOT_W-1:0];
        end
    end

    // register writes: one priority nibble per master, word chosen by index
    for (genvar m = 0; m < N_MST; m++) begin : g_prio
        localparam logic [1:0] WORD_SEL = (m < PRIO_PER_WORD) ? REG_PRIO_LO : REG_PRIO_HI;
        localparam int         NIB_LSB  = PRIO_W * (m % PRIO_PER_WORD);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prio_q[m] <= '0;
            end else if (cfg_we && (cfg_addr == WORD_SEL)) begin
                prio_q[m] <= cfg_wdata[NIB_LSB +: PRIO_W];
            end
        end
    end

    arb_rr_pick #(.N_MST(N_MST), .ID_W(ID_W)) u_rr (
        .req     (req),
        .last_id (last_q),
        .found   (rr_found),
        .win_id  (rr_win)
    );

    arb_prio_pick #(.N_MST(N_MST), .ID_W(ID_W), .PRIO_W(PRIO_W)) u_prio (
        .req     (req),
        .prio    (prio_q),
        .found   (pr_found),
        .win_id  (pr_win)
    );

    assign any_found = mode_prio_q ? pr_found : rr_found;
    assign win_id    = mode_prio_q ? pr_win   : rr_win;
    assign own_req   = |(req & grant);

    arb_slot_timer #(.SLOT_W(SLOT_W)) u_slot (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (slot_start),
        .run    (state_q == ARB_BURST),
        .lim_in (slot_q),
        .expire (expire),
        .cnt    (slot_cnt),
        .lim    (slot_lim)
    );

    // next-state decision
    always_comb begin
        state_d    = state_q;
        own_d      = own_q;
        slot_start = 1'b0;
        unique case (state_q)
            ARB_IDLE, ARB_PARK: arb_pt = 1'b1;
            ARB_BURST: arb_pt = (beat_valid && beat_last) || expire ||
                                (!own_req && !beat_valid);
            default:   arb_pt = 1'b1;
        endcase
        if (arb_pt) begin
            if (any_found) begin
                state_d    = ARB_BURST;
                own_d      = win_id;
                slot_start = 1'b1;
            end else begin
                unique case (pol_q)
                    POL_LAST: begin
                        state_d = last_vld_q ? ARB_PARK : ARB_IDLE;
                        own_d   = last_q;
                    end
                    POL_FIXED: begin
                        state_d = (int'(fix_id_q) < N_MST) ? ARB_PARK : ARB_IDLE;
                        own_d   = fix_id_q;
                    end
                    POL_NONE, POL_RSVD: begin
                        state_d = ARB_IDLE;
                        own_d   = '0;
                    end
                    default: begin
                        state_d = ARB_IDLE;
                        own_d   = '0;
                    end
                endcase
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ARB_IDLE;
            own_q      <= '0;
            last_q     <= ID_W'(N_MST - 1);
            last_vld_q <= 1'b0;
        end else begin
            state_q <= state_d;
            own_q   <= own_d;
            if (arb_pt && any_found) begin
                last_q     <= win_id;
                last_vld_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        grant_valid = (state_q != ARB_IDLE);
        grant_id    = grant_valid ? own_q : '0;
        for (int m = 0; m < N_MST; m++) begin
            grant[m] = grant_valid && (own_q == ID_W'(m));
        end
    end
endmodule

// File: rtl/slave_arbiter_chk.sv
module slave_arbiter_chk
    import arb_cfg_pkg::*;
#(
    parameter int N_MST = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_MST-1:0]  req,
    input logic              beat_valid,
    input logic              beat_last,
    input logic [N_MST-1:0]  grant,
    input logic [3:0]        grant_id,
    input logic              grant_valid,
    input arb_state_e        state_q,
    input park_pol_e         pol_q,
    input logic [FIX_W-1:0]  fix_id_q,
    input logic              expire,
    input logic [SLOT_W-1:0] slot_cnt,
    input logic [SLOT_W-1:0] slot_lim
);
    a_r2_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    a_r5_hold_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARB_BURST && beat_valid && !beat_last && !expire && ((req & grant) != '0))
        |=> $stable(grant));

    a_r6_slot_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARB_BURST && slot_lim != '0) |-> (slot_cnt < slot_lim));

    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ARB_BURST && req == '0 && pol_q == POL_NONE) |=> !grant_valid);

    a_r9_fixed_park: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ARB_BURST && req == '0 && pol_q == POL_FIXED && int'(fix_id_q) < N_MST)
        |=> (grant_valid && grant_id == $past(fix_id_q)));
endmodule

bind slave_arbiter slave_arbiter_chk #(.N_MST(N_MST)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (req),
    .beat_valid  (beat_valid),
    .beat_last   (beat_last),
    .grant       (grant),
    .grant_id    (grant_id),
    .grant_valid (grant_valid),
    .state_q     (state_q),
    .pol_q       (pol_q),
    .fix_id_q    (fix_id_q),
    .expire      (expire),
    .slot_cnt    (slot_cnt),
    .slot_lim    (slot_lim)
);

// File: tb/slave_arbiter_tb.sv
module slave_arbiter_tb;
    localparam int N = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req = '0;
    logic          beat_valid = 1'b0;
    logic          beat_last = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic [N-1:0]  grant;
    logic [3:0]    grant_id;
    logic          grant_valid;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    slave_arbiter #(.N_MST(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .beat_valid(beat_valid),
        .beat_last(beat_last), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .grant(grant), .grant_id(grant_id),
        .grant_valid(grant_valid)
    );

    // behavioural reference model
    int m_st = 0;       // 0 none, 1 parked, 2 burst
    int m_own = 0;
    int m_last = N - 1;
    int m_lastv = 0;
    int m_cnt = 0;
    int m_lim = 0;
    logic [31:0] m_cfg = '0, m_plo = '0, m_phi = '0;

    function automatic int prio_of(int m);
        if (m < 8) return int'((m_plo >> (4 * m)) & 32'hf);
        return int'((m_phi >> (4 * (m - 8))) & 32'hf);
    endfunction

    always @(posedge clk) begin
        if (rst_n) begin
            int w;
            int bp;
            bit arb;
            bit ownreq;
            w = -1;
            bp = -1;
            ownreq = (m_st != 0) && req[m_own];
            arb = (m_st != 2) || (beat_valid && beat_last) ||
                  (m_lim != 0 && m_cnt == m_lim - 1) || (!ownreq && !beat_valid);
            if (m_cfg[24]) begin
                for (int m = 0; m < N; m++)
                    if (req[m] && prio_of(m) > bp) begin w = m; bp = prio_of(m); end
            end else begin
                for (int k = 1; k <= N; k++)
                    if (w < 0 && req[(m_last + k) % N]) w = (m_last + k) % N;
            end
            if (arb) begin
                if (w >= 0) begin
                    m_st = 2; m_own = w; m_last = w; m_lastv = 1;
                    m_cnt = 0; m_lim = int'(m_cfg[7:0]);
                end else begin
                    case (int'(m_cfg[17:16]))
                        1: begin m_st = m_lastv ? 1 : 0; m_own = m_last; end
                        2: begin
                            m_own = int'(m_cfg[21:18]);
                            m_st = (m_own < N) ? 1 : 0;
                        end
                        default: m_st = 0;
                    endcase
                end
            end else if (m_lim != 0) begin
                m_cnt++;
            end
            if (cfg_we) begin
                if (cfg_addr == 2'd0) m_cfg = cfg_wdata;
                if (cfg_addr == 2'd1) m_plo = cfg_wdata;
                if (cfg_addr == 2'd2) m_phi = cfg_wdata;
            end
        end
    end

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            logic [N-1:0] eg;
            eg = (m_st != 0) ? (N'(1) << m_own) : '0;
            chk(grant == eg, cur_req, 32'(grant), 32'(eg));
            chk(grant_valid == (m_st != 0), cur_req, 32'(grant_valid), 32'(m_st != 0));
        end
    end

    task automatic step(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        step(1);
        cfg_we = 1'b0;
    endtask

    function automatic logic [31:0] cfgw(int typ, int fix, int pol, int slot);
        return (32'(typ) << 24) | (32'(fix) << 18) | (32'(pol) << 16) | 32'(slot);
    endfunction

    // beats every cycle, beat_last every 'every' cycles (0 = never)
    task automatic run(int n, int every);
        for (int c = 0; c < n; c++) begin
            beat_valid = 1'b1;
            beat_last  = (every != 0) && (c % every == every - 1);
            step(1);
        end
        beat_valid = 1'b0;
        beat_last  = 1'b0;
    endtask

    initial begin
        step(3);
        // R1: reset state
        chk(grant == '0 && !grant_valid && grant_id == 4'd0, "R1 reset", 32'(grant), 32'h0);
        rst_n = 1'b1;
        step(2);
        chk(grant == '0 && !grant_valid, "R1 idle after reset", 32'(grant), 32'h0);

        // R2 + R4: round robin among 1, 4, 7
        cur_req = "R4";
        req = 10'b0010010010;
        step(1);
        chk(grant_valid && grant_id == 4'd1, "R2 first grant", 32'(grant_id), 32'd1);
        run(30, 3);

        // R3: fixed priority, master 9 highest, 2 and 6 tie
        cur_req = "R3";
        wr(2'd1, 32'h0500_0500);     // m2=5, m6=5
        wr(2'd2, 32'h0000_0070);     // m9=7
        wr(2'd0, cfgw(1, 0, 0, 0));
        req = 10'b1001000100;
        run(8, 2);
        chk(grant_id == 4'd9, "R3 highest priority", 32'(grant_id), 32'd9);
        req = 10'b0001000100;
        run(8, 2);
        chk(grant_id == 4'd2, "R3 tie lowest index", 32'(grant_id), 32'd2);

        // R6: slot cut-off length 4 in round robin
        cur_req = "R6";
        wr(2'd0, cfgw(0, 0, 0, 4));
        req = 10'b0000100100;
        run(25, 0);
        // R6 and R10: slot 0 disables cut-off; later write does not shorten burst
        cur_req = "R10";
        wr(2'd0, cfgw(0, 0, 0, 0));
        req = 10'b0000000000;
        step(2);
        req = 10'b0000001000;
        step(2);
        req = 10'b0000101000;
        beat_valid = 1'b1;
        wr(2'd0, cfgw(0, 0, 0, 2));
        wr(2'd3, 32'hffff_ffff);
        step(10);
        chk(grant_id == 4'd3, "R10 burst not cut by new slot", 32'(grant_id), 32'd3);
        run(6, 6);

        // R5: hold until last beat with competitors present
        cur_req = "R5";
        wr(2'd0, cfgw(0, 0, 0, 0));
        req = 10'b1100000011;
        run(40, 5);

        // R11: owner drops request with no beat
        cur_req = "R11";
        req = 10'b0000010001;
        step(2);
        req = req & ~grant;
        step(1);
        req = 10'b0000010001;
        step(4);
        run(4, 4);

        // R7: release with policy 0
        cur_req = "R7";
        req = '0;
        step(3);
        chk(!grant_valid && grant == '0, "R7 no default master", 32'(grant), 32'h0);

        // R8: park on last owner
        cur_req = "R8";
        wr(2'd0, cfgw(0, 0, 1, 0));
        req = 10'b0000100000;
        run(3, 3);
        req = '0;
        step(4);
        chk(grant == 10'b0000100000, "R8 park on last", 32'(grant), 32'h20);

        // R9: park on fixed master 6, then an out-of-range ID
        cur_req = "R9";
        wr(2'd0, cfgw(0, 6, 2, 0));
        step(3);
        chk(grant == 10'b0001000000 && grant_id == 4'd6, "R9 fixed park", 32'(grant), 32'h40);
        req = 10'b0000000100;
        run(3, 3);
        req = '0;
        step(2);
        chk(grant_id == 4'd6, "R9 back to fixed park", 32'(grant_id), 32'd6);
        wr(2'd0, cfgw(0, 12, 2, 0));
        step(3);
        chk(!grant_valid, "R9 out-of-range fixed id", 32'(grant_valid), 32'd0);

        // R3 + R6 mixed: priority with cut-off
        cur_req = "R3";
        wr(2'd0, cfgw(1, 0, 0, 3));
        req = 10'b1111111111;
        run(30, 0);
        req = '0;
        step(3);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule